// File: doc/BRIEF.md
# Register Write-Back Stage with Deferred Move

This block is the register array and write-back stage of a small in-order pipeline. Each cycle one instruction may present two read indices and, optionally, a write. The operands it fetches are returned combinationally in the same cycle. A write is held for one cycle in a single write-back slot before it reaches the array. While it waits there, an ordinary write is forwarded to the reads of the next instruction.

A deferred move is a special instruction form. It also copies the value read on operand port A into a destination. However, its slot entry is marked so that the next instruction does not see it through forwarding and reads the array contents instead. The entry reaches the array only when that next valid instruction issues. Interrupts are masked while the entry waits. Two deferred moves issued back to back in opposite directions therefore exchange two registers through a single write port.

A build option turns the top register index into a window onto the write-back slot. In that mode every write behaves as deferred, and the newest result can still be read at once through the top index. Only the lower indices are real registers.

Top module: `dmov_wb_stage`

## Requirements
- R1: While reset is asserted, and after it, every register reads 0 and `irqHold` is 0.
- R2: `opKind` 1 writes `resData` to `dstIdx`. An instruction in the next cycle that reads `dstIdx` receives the new value through forwarding, and the value stays in the array afterwards.
- R3: `opKind` 3 is an ordinary move. It copies the value on `operandA` into `dstIdx`, and this write is forwarded in the same way as R2.
- R4: `opKind` 2 is a deferred move. It copies the value on `operandA` into `dstIdx`. An instruction in the next cycle that reads `dstIdx` gets the value that was there before, and the instruction after that sees the moved value.
- R5: A pending deferred write is held across cycles in which `instValid` is 0. It reaches the array at the clock edge that ends the next cycle in which `instValid` is 1. `irqHold` is 1 from the cycle after the deferred move up to and including that cycle.
- R6: A deferred move rA←rB followed in the next cycle by a deferred move rB←rA swaps the contents of rA and rB.
- R7: Writes reach the array in issue order. A deferred write to a register followed by an ordinary write to the same register leaves the ordinary value.
- R8: `opKind` 0, or `instValid` 0, writes no register.
- R9: With `BYPASS_TOP`=1, reading index 15 returns the most recently captured result from the cycle after capture onward. No write is forwarded under its own destination index. A write whose destination is 15 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | An instruction issues this cycle |
| opKind | input | 2 | 0 reads only, 1 write result, 2 deferred move, 3 ordinary move |
| srcA | input | 4 | Read index for operand A (also the move source) |
| srcB | input | 4 | Read index for operand B |
| dstIdx | input | 4 | Destination register index |
| resData | input | 16 | Result written by opKind 1 |
| operandA | output | 16 | Value fetched for srcA |
| operandB | output | 16 | Value fetched for srcB |
| irqHold | output | 1 | Interrupts must not be taken this cycle |

## Verification
The bench builds two copies of the block. The first uses `BYPASS_TOP`=0, so all sixteen indices are real registers and forwarding is active. This copy reaches forwarding, the deferred move, held entries across idle cycles, the swap and write ordering. The second uses `BYPASS_TOP`=1, which brings the top-index window into reach. It shows that a result is readable there while its named destination still returns the old value, and that a write aimed at index 15 commits nowhere.

// File: rtl/dmov_pkg.sv
package dmov_pkg;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_DMOV  = 2'd2,
    KIND_MOVE  = 2'd3
  } instKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;        // load write-back slot this cycle
    logic captureFromOpA; // slot value comes from operand A
    logic commit;         // slot contents go to the array at this edge
    logic fwdEn;          // slot may be forwarded to this cycle's reads
  } wbStrobe_t;

endpackage

// File: rtl/dmov_wb_ctrl.sv
module dmov_wb_ctrl
  import dmov_pkg::*;
#(
  parameter int BYPASS_TOP = 0
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      instValid,
  input  instKind_e kind,
  output wbStrobe_t strobe,
  output logic      irqHold
);

  logic slotValid;
  logic slotDeferred;
  logic captureNow;
  logic captureDeferred;
  logic commitNow;

  assign captureNow      = instValid && (kind != KIND_NONE);
  // in window mode every write is deferred
  assign captureDeferred = (BYPASS_TOP != 0) || (kind == KIND_DMOV);
  // a deferred entry waits for the next issued instruction's operand read
  assign commitNow       = slotValid && (!slotDeferred || instValid);

  always_comb begin
    strobe                = '0;
    strobe.capture        = captureNow;
    strobe.captureFromOpA = (kind == KIND_DMOV) || (kind == KIND_MOVE);
    strobe.commit         = commitNow;
    strobe.fwdEn          = slotValid && !slotDeferred && (BYPASS_TOP == 0);
  end

  assign irqHold = slotValid && slotDeferred;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid    <= 1'b0;
      slotDeferred <= 1'b0;
    end else if (captureNow) begin
      slotValid    <= 1'b1;
      slotDeferred <= captureDeferred;
    end else if (commitNow) begin
      slotValid    <= 1'b0;
      slotDeferred <= 1'b0;
    end
  end

endmodule

// File: rtl/dmov_wb_dpath.sv
module dmov_wb_dpath
  import dmov_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int IDX_W      = 4,
  parameter int BYPASS_TOP = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  wbStrobe_t         strobe,
  input  logic [IDX_W-1:0]  srcA,
  input  logic [IDX_W-1:0]  srcB,
  input  logic [IDX_W-1:0]  dstIdx,
  input  logic [DATA_W-1:0] resData,
  output logic [DATA_W-1:0] operandA,
  output logic [DATA_W-1:0] operandB
);

  localparam int NREGS = 1 << IDX_W;
  localparam int NPORTS = 2;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NREGS - 1);

  logic [DATA_W-1:0] regs [NREGS];
  logic [IDX_W-1:0]  slotIdx;
  logic [DATA_W-1:0] slotData;
  logic [IDX_W-1:0]  rdIdx [NPORTS];
  logic [DATA_W-1:0] rdVal [NPORTS];
  logic              commitAllowed;

  assign rdIdx[0] = srcA;
  assign rdIdx[1] = srcB;

  for (genvar p = 0; p < NPORTS; p++) begin : g_read
    if (BYPASS_TOP != 0) begin : g_window
      always_comb begin
        if (rdIdx[p] == TOP_IDX)
          rdVal[p] = slotData;
        else
          rdVal[p] = regs[rdIdx[p]];
      end
    end else begin : g_plain
      always_comb begin
        if (strobe.fwdEn && (slotIdx == rdIdx[p]))
          rdVal[p] = slotData;
        else
          rdVal[p] = regs[rdIdx[p]];
      end
    end
  end

  assign operandA = rdVal[0];
  assign operandB = rdVal[1];

  if (BYPASS_TOP != 0) begin : g_commit_window
    assign commitAllowed = strobe.commit && (slotIdx != TOP_IDX);
  end else begin : g_commit_plain
    assign commitAllowed = strobe.commit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotIdx  <= '0;
      slotData <= '0;
    end else if (strobe.capture) begin
      slotIdx  <= dstIdx;
      slotData <= strobe.captureFromOpA ? rdVal[0] : resData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (commitAllowed) begin
      regs[slotIdx] <= slotData;
    end
  end

endmodule

// File: rtl/dmov_wb_stage.sv
module dmov_wb_stage
  import dmov_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int IDX_W      = 4,
  parameter int BYPASS_TOP = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [1:0]        opKind,
  input  logic [IDX_W-1:0]  srcA,
  input  logic [IDX_W-1:0]  srcB,
  input  logic [IDX_W-1:0]  dstIdx,
  input  logic [DATA_W-1:0] resData,
  output logic [DATA_W-1:0] operandA,
  output logic [DATA_W-1:0] operandB,
  output logic              irqHold
);

  wbStrobe_t strobe;

  dmov_wb_ctrl #(.BYPASS_TOP(BYPASS_TOP)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .kind      (instKind_e'(opKind)),
    .strobe    (strobe),
    .irqHold   (irqHold)
  );

  dmov_wb_dpath #(
    .DATA_W     (DATA_W),
    .IDX_W      (IDX_W),
    .BYPASS_TOP (BYPASS_TOP)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .srcA     (srcA),
    .srcB     (srcB),
    .dstIdx   (dstIdx),
    .resData  (resData),
    .operandA (operandA),
    .operandB (operandB)
  );

endmodule

// File: rtl/dmov_wb_stage_chk.sv
module dmov_wb_stage_chk #(
  parameter int DATA_W     = 16,
  parameter int IDX_W      = 4,
  parameter int BYPASS_TOP = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              instValid,
  input logic [1:0]        opKind,
  input logic [IDX_W-1:0]  srcA,
  input logic [IDX_W-1:0]  srcB,
  input logic [IDX_W-1:0]  dstIdx,
  input logic [DATA_W-1:0] resData,
  input logic [DATA_W-1:0] operandA,
  input logic [DATA_W-1:0] operandB,
  input logic              irqHold
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'((1 << IDX_W) - 1);

  p_fwd_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (BYPASS_TOP == 0 && instValid && opKind == 2'd1)
    |=> (srcA != $past(dstIdx)) || (operandA == $past(resData)));

  p_fwd_move_r3: assert property (@(posedge clk) disable iff (!rstN)
    (BYPASS_TOP == 0 && instValid && opKind == 2'd3)
    |=> (srcA != $past(dstIdx)) || (operandA == $past(operandA)));

  p_plain_no_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (BYPASS_TOP == 0 && instValid && opKind[0])
    |=> !irqHold);

  p_hold_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && opKind == 2'd2) |=> irqHold);

  p_hold_wait_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irqHold && !instValid) |=> irqHold);

  p_hold_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irqHold && instValid && opKind == 2'd0) |=> !irqHold);

  p_window_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (BYPASS_TOP != 0 && instValid && opKind == 2'd1)
    |=> (srcA != TOP_IDX) || (operandA == $past(resData)));

  p_no_write_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!irqHold && instValid && opKind == 2'd0) |=> !irqHold);

endmodule

bind dmov_wb_stage dmov_wb_stage_chk #(
  .DATA_W     (DATA_W),
  .IDX_W      (IDX_W),
  .BYPASS_TOP (BYPASS_TOP)
) chk (
  .clk       (clk),
  .rstN      (rstN),
  .instValid (instValid),
  .opKind    (opKind),
  .srcA      (srcA),
  .srcB      (srcB),
  .dstIdx    (dstIdx),
  .resData   (resData),
  .operandA  (operandA),
  .operandB  (operandB),
  .irqHold   (irqHold)
);

// File: tb/dmov_wb_stage_test.sv
`timescale 1ns/100ps
module dmov_wb_stage_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        instValid, bValid;
  logic [1:0]  opKind, bKind;
  logic [3:0]  srcA, srcB, dstIdx, bA, bB, bD;
  logic [15:0] resData, bRes;
  logic [15:0] operandA, operandB, bOpA, bOpB;
  logic        irqHold, bIrq;

  int checks = 0;
  int errors = 0;

  dmov_wb_stage #(.DATA_W(16), .IDX_W(4), .BYPASS_TOP(0)) uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .opKind(opKind),
    .srcA(srcA), .srcB(srcB), .dstIdx(dstIdx), .resData(resData),
    .operandA(operandA), .operandB(operandB), .irqHold(irqHold)
  );

  dmov_wb_stage #(.DATA_W(16), .IDX_W(4), .BYPASS_TOP(1)) uutByp (
    .clk(clk), .rstN(rstN), .instValid(bValid), .opKind(bKind),
    .srcA(bA), .srcB(bB), .dstIdx(bD), .resData(bRes),
    .operandA(bOpA), .operandB(bOpB), .irqHold(bIrq)
  );

  // {valid, kind, srcA, srcB, dst, resData, expA, expB, expIrq}
  localparam int NVEC = 21;
  localparam logic [63:0] VECS [NVEC] = '{
    {1'b1, 2'd1, 4'd0, 4'd0, 4'd1, 16'h1111, 16'h0000, 16'h0000, 1'b0}, // R2
    {1'b1, 2'd1, 4'd1, 4'd2, 4'd2, 16'h2222, 16'h1111, 16'h0000, 1'b0}, // R2 forward
    {1'b1, 2'd3, 4'd2, 4'd1, 4'd3, 16'h0000, 16'h2222, 16'h1111, 1'b0}, // R3
    {1'b1, 2'd0, 4'd3, 4'd2, 4'd0, 16'hFFFF, 16'h2222, 16'h2222, 1'b0}, // R3 forward, R8
    {1'b1, 2'd0, 4'd0, 4'd0, 4'd0, 16'h0000, 16'h0000, 16'h0000, 1'b0}, // R8 r0 untouched
    {1'b1, 2'd2, 4'd1, 4'd0, 4'd4, 16'hDEAD, 16'h1111, 16'h0000, 1'b0}, // R4
    {1'b1, 2'd0, 4'd4, 4'd4, 4'd0, 16'h0000, 16'h0000, 16'h0000, 1'b1}, // R4 old value
    {1'b1, 2'd0, 4'd4, 4'd0, 4'd0, 16'h0000, 16'h1111, 16'h0000, 1'b0}, // R4 new value
    {1'b1, 2'd2, 4'd2, 4'd0, 4'd1, 16'h0000, 16'h2222, 16'h0000, 1'b0}, // R6 r1<-r2
    {1'b1, 2'd2, 4'd1, 4'd2, 4'd2, 16'h0000, 16'h1111, 16'h2222, 1'b1}, // R6 r2<-r1
    {1'b1, 2'd0, 4'd1, 4'd2, 4'd0, 16'h0000, 16'h2222, 16'h2222, 1'b1}, // R6
    {1'b1, 2'd0, 4'd1, 4'd2, 4'd0, 16'h0000, 16'h2222, 16'h1111, 1'b0}, // R6 swapped
    {1'b1, 2'd2, 4'd3, 4'd0, 4'd5, 16'h0000, 16'h2222, 16'h0000, 1'b0}, // R5
    {1'b0, 2'd1, 4'd5, 4'd0, 4'd6, 16'hBEEF, 16'h0000, 16'h0000, 1'b1}, // R5 held
    {1'b0, 2'd0, 4'd5, 4'd0, 4'd0, 16'h0000, 16'h0000, 16'h0000, 1'b1}, // R5 held
    {1'b1, 2'd1, 4'd5, 4'd6, 4'd6, 16'h6666, 16'h0000, 16'h0000, 1'b1}, // R5 commit, R8
    {1'b1, 2'd0, 4'd5, 4'd6, 4'd0, 16'h0000, 16'h2222, 16'h6666, 1'b0}, // R5
    {1'b1, 2'd2, 4'd6, 4'd0, 4'd7, 16'h0000, 16'h6666, 16'h0000, 1'b0}, // R7
    {1'b1, 2'd1, 4'd7, 4'd0, 4'd7, 16'h7777, 16'h0000, 16'h0000, 1'b1}, // R7
    {1'b1, 2'd0, 4'd7, 4'd0, 4'd0, 16'h0000, 16'h7777, 16'h0000, 1'b0}, // R7
    {1'b0, 2'd0, 4'd7, 4'd15, 4'd0, 16'h0000, 16'h7777, 16'h0000, 1'b0} // R7 final
  };

  function automatic string rowReq(input int row);
    if (row < 2) return "R2";
    else if (row < 3) return "R3";
    else if (row < 5) return "R8";
    else if (row < 8) return "R4";
    else if (row < 12) return "R6";
    else if (row < 17) return "R5";
    else return "R7";
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    instValid = 0; opKind = 0; srcA = 0; srcB = 0; dstIdx = 0; resData = 0;
    bValid = 0; bKind = 0; bA = 0; bB = 0; bD = 0; bRes = 0;
    repeat (3) @(negedge clk);

    // R1: registers read zero during reset
    for (int i = 0; i < 16; i++) begin
      srcA = 4'(i); srcB = 4'(15 - i); bA = 4'(i);
      #0.5;
      check("R1", "reset operandA", operandA, 16'h0);
      check("R1", "reset operandB", operandB, 16'h0);
      check("R1", "reset window operandA", bOpA, 16'h0);
    end
    check("R1", "reset irqHold", {15'd0, irqHold}, 16'h0);
    @(negedge clk);
    rstN = 1'b1;

    // table walk on the forwarding build
    for (int row = 0; row < NVEC; row++) begin
      @(negedge clk);
      {instValid, opKind, srcA, srcB, dstIdx, resData} = VECS[row][63:33];
      #1;
      check(rowReq(row), $sformatf("row %0d operandA", row), operandA, VECS[row][32:17]);
      check(rowReq(row), $sformatf("row %0d operandB", row), operandB, VECS[row][16:1]);
      check(rowReq(row), $sformatf("row %0d irqHold", row), {15'd0, irqHold}, {15'd0, VECS[row][0]});
    end
    @(negedge clk);
    instValid = 0;

    // R9: window build
    @(negedge clk);
    bValid = 1; bKind = 2'd1; bA = 0; bB = 0; bD = 4'd2; bRes = 16'hA5A5;
    #1; check("R9", "window idle operandA", bOpA, 16'h0);
    @(negedge clk);
    bKind = 2'd0; bA = 4'd15; bB = 4'd2;
    #1;
    check("R9", "window top reads result", bOpA, 16'hA5A5);
    check("R9", "destination not forwarded", bOpB, 16'h0);
    check("R9", "window write holds irq", {15'd0, bIrq}, 16'h1);
    @(negedge clk);
    bA = 4'd2; bB = 4'd15;
    #1;
    check("R9", "destination committed", bOpA, 16'hA5A5);
    check("R9", "window retains result", bOpB, 16'hA5A5);
    check("R9", "irq released", {15'd0, bIrq}, 16'h0);
    @(negedge clk);
    bKind = 2'd1; bA = 0; bD = 4'd15; bRes = 16'h0F0F;
    @(negedge clk);
    bKind = 2'd0; bA = 4'd15;
    #1; check("R9", "top-destination result visible", bOpA, 16'h0F0F);
    @(negedge clk);
    bValid = 0; bA = 4'd2; bB = 4'd0;
    #1;
    check("R9", "top-destination write left r2", bOpA, 16'hA5A5);
    check("R9", "top-destination write left r0", bOpB, 16'h0000);

    // R1: reset in mid-run clears the array and the hold
    @(negedge clk);
    instValid = 1; opKind = 2'd2; srcA = 4'd1; dstIdx = 4'd9;
    @(negedge clk);
    instValid = 0; opKind = 0; srcA = 4'd1; srcB = 4'd7;
    #1; check("R1", "hold before reset", {15'd0, irqHold}, 16'h1);
    rstN = 1'b0;
    #0.5;
    check("R1", "mid-run reset r1", operandA, 16'h0);
    check("R1", "mid-run reset r7", operandB, 16'h0);
    check("R1", "mid-run reset irqHold", {15'd0, irqHold}, 16'h0);
    @(negedge clk);
    rstN = 1'b1;
    srcA = 4'd9;
    #1; check("R1", "pending write dropped by reset", operandA, 16'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule